// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Command Engine

This block is the command engine of a 256-byte serial memory that answers as a slave on a two-wire bus. A bus front end cleans up the clock and data pins and hands the engine one-cycle event strobes: a START event, a STOP event, an SCL rising strobe and an SCL falling strobe. The bus SDA level is sampled on the rising strobe. The engine matches the control byte and loads a word address. It serves byte and page writes, current-address reads, random reads and sequential reads. It pulls SDA low through an open-drain enable to acknowledge and to send read data.

Write data goes out on a page-buffer port, one strobe per byte, with the target address. A STOP that closes a write asks the page buffer to commit. A START that cuts a write short tells the buffer to discard what it holds. Read data comes from a synchronous memory port with one cycle of latency. A single address pointer serves every mode. Writes step only the low three pointer bits, so they stay inside an 8-byte page. Reads step the whole pointer. The nonvolatile write timing lives outside the block and is reported back on the `busy` input.

The front end must leave at least three clock cycles between consecutive strobes.

Top module: `twi_mem_engine`

## Requirements
- R1: After reset `sdaDrvLow`, `pbWrEn`, `memRdEn`, `pbCommit` and `pbDrop` are 0 and the address pointer is 0, so a first current-address read returns the byte at address 0x00.
- R2: A control byte is matched when its bits 7:4 equal 4'b1010. Bits 3:1 are ignored. Bit 0 selects read (1) or write (0). A control byte that does not match gets no acknowledge, and the engine ignores all bus activity until the next START.
- R3: While `busy` is 1 in the cycle of the eighth control-byte rising strobe, the control byte gets no acknowledge.
- R4: To acknowledge a byte, `sdaDrvLow` goes to 1 on the falling strobe that follows the eighth rising strobe. It stays 1 through the ninth high phase and returns to 0 on the ninth falling strobe, unless read data follows.
- R5: In a write, the byte after the control byte loads the pointer. Each later byte is acknowledged and presented on `pbWrEn`/`pbAddr`/`pbData` at the pointer address. After each such byte the pointer's low three bits step by one with wrap, and its upper five bits are kept.
- R6: A STOP after at least one acknowledged write data byte pulses `pbCommit` for one cycle in the next cycle. A START in that situation pulses `pbDrop` instead. The pointer keeps its value in both cases.
- R7: A read returns the byte at the pointer, and the pointer then moves one past it. A current-address read therefore returns the byte after the last one read or written, with page wrap after writes.
- R8: During a read, a master acknowledge (SDA 0 on the ninth rising strobe) makes the engine send the next byte. The read pointer wraps from 0xFF to 0x00.
- R9: A master no-acknowledge after a read byte leaves SDA released. The engine then drives nothing until the next START or STOP.
- R10: A START or STOP at any bit position ends the transfer and releases SDA. A partly received byte is never presented on the page-buffer port. STOP returns the engine to idle, and START begins a new control byte.
- R11: Read data is sent MSB first. Each bit is placed on the line (`sdaDrvLow` = inverted bit) at a falling strobe and does not change until the next falling strobe. SDA is released during the ninth clock of each read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startEv | input | 1 | One-cycle START event from the front end |
| stopEv | input | 1 | One-cycle STOP event from the front end |
| sclRise | input | 1 | One-cycle SCL rising strobe (SDA sample point) |
| sclFall | input | 1 | One-cycle SCL falling strobe (SDA change point) |
| sdaIn | input | 1 | Sampled bus SDA level |
| busy | input | 1 | Nonvolatile write cycle in progress |
| sdaDrvLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| pbWrEn | output | 1 | Page-buffer byte write strobe |
| pbAddr | output | 8 | Page-buffer byte address |
| pbData | output | 8 | Page-buffer byte data |
| pbCommit | output | 1 | Commit request to the page buffer after STOP |
| pbDrop | output | 1 | Discard request to the page buffer after START |
| memRdEn | output | 1 | Synchronous memory read enable |
| memRdAddr | output | 8 | Memory read address |
| memRdData | input | 8 | Memory read data, valid one cycle after the enable |

## Verification
Two functions can meet in a single cycle: the acknowledge decision on the eighth control-byte bit, and the `busy` input from the write timer changing. The bench changes `busy` on the exact cycle that carries the eighth rising strobe, once from 0 to 1 and once from 1 to 0. Only the value present in that cycle may decide the outcome, so the first case must give no acknowledge and the second must give one. The same bench also checks that a STOP or START arriving mid-byte leaves no stray page-buffer write, and that the pointer set by the word address survives the abort.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftIn;     // shift the sampled SDA bit into the receive register
    logic cntInc;      // advance the bit counter
    logic cntClr;      // restart the bit counter
    logic ptrLoad;     // load the pointer from the received byte
    logic ptrIncPage;  // step the pointer inside its page
    logic ptrIncFull;  // step the pointer across the whole array
    logic txShift;     // move the transmit register up one bit
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_ADDR,
    S_WDATA,
    S_RDATA
  } engState_e;

endpackage

// File: rtl/twi_mem_dp.sv
module twi_mem_dp
  import twi_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaIn,
  input  logic              rdIssue,
  input  logic [DATA_W-1:0] memRdData,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBitCur,
  output logic              txBitNext,
  output logic [ADDR_W-1:0] ptr
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] txReg;
  logic              rdLatch;
  logic [ADDR_W-1:0] ptrPageNext;

  assign rxByte    = {shiftReg[DATA_W-2:0], sdaIn};
  assign txBitCur  = txReg[DATA_W-1];
  assign txBitNext = txReg[DATA_W-2];

  // page-local increment; a page as wide as the array degenerates to a plain increment
  generate
    if (PAGE_W >= ADDR_W) begin : g_pageFull
      assign ptrPageNext = ptr + 1'b1;
    end else begin : g_pageSplit
      assign ptrPageNext = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      ptr      <= '0;
      txReg    <= '0;
      rdLatch  <= 1'b0;
    end else begin
      if (strobe.shiftIn) shiftReg <= rxByte;

      if (strobe.cntClr)      bitCnt <= '0;
      else if (strobe.cntInc) bitCnt <= bitCnt + 1'b1;

      if (strobe.ptrLoad)         ptr <= rxByte[ADDR_W-1:0];
      else if (strobe.ptrIncPage) ptr <= ptrPageNext;
      else if (strobe.ptrIncFull) ptr <= ptr + 1'b1;

      rdLatch <= rdIssue;
      if (rdLatch)             txReg <= memRdData;
      else if (strobe.txShift) txReg <= {txReg[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/twi_mem_ctrl.sv
module twi_mem_ctrl
  import twi_mem_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CNT_W    = 4,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startEv,
  input  logic             stopEv,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             sdaIn,
  input  logic             busy,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic [3:0]       rxCode,
  input  logic             rxRw,
  input  logic             txBitCur,
  input  logic             txBitNext,
  output dpStrobe_t        strobe,
  output logic             rdIssue,
  output logic             pbWrEn,
  output logic             sdaDrvLow,
  output logic             pbCommit,
  output logic             pbDrop
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(DATA_W - 1);

  engState_e state, stN;
  logic      ackGo, ackN;
  logic      isRead, isReadN;
  logic      wrPending, wrPendN;
  logic      drvN, commitN, dropN;
  logic      isRx, ctrlMatch;

  assign isRx      = (state == S_CTRL) || (state == S_ADDR) || (state == S_WDATA);
  assign ctrlMatch = (rxCode == DEV_CODE) && !busy;

  always_comb begin
    stN     = state;
    ackN    = ackGo;
    isReadN = isRead;
    wrPendN = wrPending;
    drvN    = sdaDrvLow;
    commitN = 1'b0;
    dropN   = 1'b0;
    strobe  = '0;
    rdIssue = 1'b0;
    pbWrEn  = 1'b0;

    if (startEv) begin
      stN           = S_CTRL;
      strobe.cntClr = 1'b1;
      drvN          = 1'b0;
      wrPendN       = 1'b0;
      dropN         = wrPending;
    end else if (stopEv) begin
      stN           = S_IDLE;
      strobe.cntClr = 1'b1;
      drvN          = 1'b0;
      wrPendN       = 1'b0;
      commitN       = wrPending;
    end else if (isRx) begin
      if (sclRise) begin
        if (bitCnt < CNT_LAST) begin
          strobe.shiftIn = 1'b1;
          strobe.cntInc  = 1'b1;
          if (bitCnt == CNT_PRE) begin
            // byte complete on this strobe
            unique case (state)
              S_CTRL: begin
                ackN    = ctrlMatch;
                isReadN = rxRw;
                if (ctrlMatch && rxRw) begin
                  rdIssue           = 1'b1;
                  strobe.ptrIncFull = 1'b1;
                end
              end
              S_ADDR: begin
                ackN           = 1'b1;
                strobe.ptrLoad = 1'b1;
              end
              default: begin
                ackN              = 1'b1;
                pbWrEn            = 1'b1;
                strobe.ptrIncPage = 1'b1;
                wrPendN           = 1'b1;
              end
            endcase
          end
        end else if (bitCnt == CNT_LAST) begin
          strobe.cntInc = 1'b1;
        end
      end else if (sclFall) begin
        if (bitCnt == CNT_LAST) begin
          if (ackGo) drvN = 1'b1;
          else       stN  = S_IDLE;
        end else if (bitCnt == CNT_ACK) begin
          strobe.cntClr = 1'b1;
          drvN          = 1'b0;
          if (state == S_CTRL) begin
            if (isRead) begin
              stN  = S_RDATA;
              drvN = !txBitCur;
            end else begin
              stN = S_ADDR;
            end
          end else begin
            stN = S_WDATA;
          end
        end
      end
    end else if (state == S_RDATA) begin
      if (sclRise) begin
        if (bitCnt < CNT_LAST) begin
          strobe.cntInc = 1'b1;
        end else if (bitCnt == CNT_LAST) begin
          if (!sdaIn) begin
            strobe.cntInc     = 1'b1;
            rdIssue           = 1'b1;
            strobe.ptrIncFull = 1'b1;
          end else begin
            stN = S_IDLE;
          end
        end
      end else if (sclFall) begin
        if ((bitCnt != '0) && (bitCnt < CNT_LAST)) begin
          drvN           = !txBitNext;
          strobe.txShift = 1'b1;
        end else if (bitCnt == CNT_LAST) begin
          drvN = 1'b0;
        end else if (bitCnt == CNT_ACK) begin
          strobe.cntClr = 1'b1;
          drvN          = !txBitCur;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      ackGo     <= 1'b0;
      isRead    <= 1'b0;
      wrPending <= 1'b0;
      sdaDrvLow <= 1'b0;
      pbCommit  <= 1'b0;
      pbDrop    <= 1'b0;
    end else begin
      state     <= stN;
      ackGo     <= ackN;
      isRead    <= isReadN;
      wrPending <= wrPendN;
      sdaDrvLow <= drvN;
      pbCommit  <= commitN;
      pbDrop    <= dropN;
    end
  end

endmodule

// File: rtl/twi_mem_engine.sv
module twi_mem_engine
  import twi_mem_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PAGE_W   = 3,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaIn,
  input  logic              busy,
  output logic              sdaDrvLow,
  output logic              pbWrEn,
  output logic [ADDR_W-1:0] pbAddr,
  output logic [DATA_W-1:0] pbData,
  output logic              pbCommit,
  output logic              pbDrop,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 2);

  dpStrobe_t         strobe;
  logic              rdIssue;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] rxByte;
  logic              txBitCur, txBitNext;
  logic [ADDR_W-1:0] ptr;

  twi_mem_ctrl #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .DEV_CODE(DEV_CODE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startEv  (startEv),
    .stopEv   (stopEv),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .sdaIn    (sdaIn),
    .busy     (busy),
    .bitCnt   (bitCnt),
    .rxCode   (rxByte[DATA_W-1 -: 4]),
    .rxRw     (rxByte[0]),
    .txBitCur (txBitCur),
    .txBitNext(txBitNext),
    .strobe   (strobe),
    .rdIssue  (rdIssue),
    .pbWrEn   (pbWrEn),
    .sdaDrvLow(sdaDrvLow),
    .pbCommit (pbCommit),
    .pbDrop   (pbDrop)
  );

  twi_mem_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PAGE_W(PAGE_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sdaIn    (sdaIn),
    .rdIssue  (rdIssue),
    .memRdData(memRdData),
    .bitCnt   (bitCnt),
    .rxByte   (rxByte),
    .txBitCur (txBitCur),
    .txBitNext(txBitNext),
    .ptr      (ptr)
  );

  assign pbAddr    = ptr;
  assign pbData    = rxByte;
  assign memRdEn   = rdIssue;
  assign memRdAddr = ptr;

endmodule

// File: rtl/twi_mem_chk.sv
module twi_mem_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              startEv,
  input logic              stopEv,
  input logic              sclFall,
  input logic              sdaDrvLow,
  input logic              pbWrEn,
  input logic [ADDR_W-1:0] pbAddr,
  input logic              pbCommit,
  input logic              pbDrop,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr
);

  logic [ADDR_W-1:0] lastWr, lastRd, expWr;
  logic              wrSeen, rdSeen;

  assign expWr = {lastWr[ADDR_W-1:PAGE_W], lastWr[PAGE_W-1:0] + 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastWr <= '0;
      lastRd <= '0;
      wrSeen <= 1'b0;
      rdSeen <= 1'b0;
    end else if (startEv || stopEv) begin
      wrSeen <= 1'b0;
      rdSeen <= 1'b0;
    end else begin
      if (pbWrEn)  begin lastWr <= pbAddr;    wrSeen <= 1'b1; end
      if (memRdEn) begin lastRd <= memRdAddr; rdSeen <= 1'b1; end
    end
  end

  p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    pbCommit |-> $past(stopEv));

  p_drop_on_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    pbDrop |-> $past(startEv));

  p_sda_moves_on_fall_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> $past(sclFall || startEv || stopEv));

  p_release_on_event_r10: assert property (@(posedge clk) disable iff (!rstN)
    (startEv || stopEv) |=> !sdaDrvLow);

  p_page_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pbWrEn && wrSeen) |-> (pbAddr == expWr));

  p_read_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && rdSeen) |-> (memRdAddr == lastRd + 1'b1));

  p_port_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pbWrEn, memRdEn, pbCommit, pbDrop}));

endmodule

bind twi_mem_engine twi_mem_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startEv  (startEv),
  .stopEv   (stopEv),
  .sclFall  (sclFall),
  .sdaDrvLow(sdaDrvLow),
  .pbWrEn   (pbWrEn),
  .pbAddr   (pbAddr),
  .pbCommit (pbCommit),
  .pbDrop   (pbDrop),
  .memRdEn  (memRdEn),
  .memRdAddr(memRdAddr)
);

// File: tb/sim_twi_mem_engine.sv
module sim_twi_mem_engine;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startEv = 1'b0, stopEv = 1'b0, sclRise = 1'b0, sclFall = 1'b0;
  logic       mSda = 1'b1;
  logic       forceBusy = 1'b0;
  logic       busy;
  logic       sdaIn;
  logic       sdaDrvLow, pbWrEn, pbCommit, pbDrop, memRdEn;
  logic [7:0] pbAddr, pbData, memRdAddr;
  logic [7:0] memRdData = 8'h00;

  logic [7:0] mem    [256];
  logic [7:0] refMem [256];
  logic [7:0] pendA  [16];
  logic [7:0] pendD  [16];
  logic [7:0] wrLog  [64];
  int         pendCnt = 0, wrCnt = 0, commitCnt = 0, dropCnt = 0, busyCnt = 0;
  int         nChecks = 0, nErr = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign sdaIn = mSda & ~sdaDrvLow;
  assign busy  = forceBusy | (busyCnt != 0);

  twi_mem_engine u0 (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .sclRise(sclRise), .sclFall(sclFall), .sdaIn(sdaIn), .busy(busy),
    .sdaDrvLow(sdaDrvLow), .pbWrEn(pbWrEn), .pbAddr(pbAddr), .pbData(pbData),
    .pbCommit(pbCommit), .pbDrop(pbDrop), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData)
  );

  // memory and page-buffer models
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memRdAddr];
    if (busyCnt != 0) busyCnt <= busyCnt - 1;
    if (pbWrEn) begin
      if (pendCnt < 16) begin pendA[pendCnt] = pbAddr; pendD[pendCnt] = pbData; pendCnt++; end
      if (wrCnt < 64) wrLog[wrCnt] = pbAddr;
      wrCnt++;
    end
    if (pbCommit) begin
      for (int k = 0; k < pendCnt; k++) mem[pendA[k]] = pendD[k];
      pendCnt = 0;
      commitCnt++;
      busyCnt <= 200;
    end
    if (pbDrop) begin pendCnt = 0; dropCnt++; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    @(negedge clk) begin startEv = 1'b1; mSda = 1'b1; end
    @(negedge clk) startEv = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic busStop();
    @(negedge clk) begin stopEv = 1'b1; mSda = 1'b1; end
    @(negedge clk) stopEv = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clkRise();
    @(negedge clk) sclRise = 1'b1;
    @(negedge clk) sclRise = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clkFall();
    @(negedge clk) sclFall = 1'b1;
    @(negedge clk) sclFall = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic mBit(input logic b);
    @(negedge clk) mSda = b;
    clkRise();
    clkFall();
  endtask

  // master sends a byte; reports ack in the ninth high phase and release after it
  task automatic sendByte(input logic [7:0] b, output logic acked, output logic held, output logic rel);
    for (int i = 7; i >= 0; i--) mBit(b[i]);
    @(negedge clk) mSda = 1'b1;
    clkRise();
    acked = sdaDrvLow;
    @(negedge clk);
    held = sdaDrvLow;
    clkFall();
    rel = !sdaDrvLow;
  endtask

  task automatic sendB(input logic [7:0] b, output logic acked);
    logic h, r;
    sendByte(b, acked, h, r);
  endtask

  // master receives a byte; stableOk flags a bit that moved in a high phase or SDA held in the ninth clock
  task automatic recvByte(input logic mAck, output logic [7:0] d, output logic stableOk);
    stableOk = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mSda = 1'b1;
      clkRise();
      d[i] = sdaIn;
      @(negedge clk);
      if (sdaIn != d[i]) stableOk = 1'b0;
      clkFall();
    end
    @(negedge clk) mSda = !mAck;
    clkRise();
    if (sdaDrvLow) stableOk = 1'b0;
    clkFall();
    mSda = 1'b1;
  endtask

  task automatic seqRead(input logic [7:0] a0, input int n, input string tag);
    logic [7:0] d;
    logic       st;
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, d, st);
      chk(d == refMem[8'(a0 + k)], tag, d, refMem[8'(a0 + k)]);
      chk(st, {tag, " R11 bit stability"}, st, 1);
    end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic randomRead(input logic [7:0] a, input int n, input string tag);
    logic ak;
    busStart();
    sendB(8'hA0, ak);
    sendB(a, ak);
    busStart();
    sendB(8'hA1, ak);
    chk(ak, {tag, " read ctrl ack"}, ak, 1);
    seqRead(a, n, tag);
    busStop();
  endtask

  task automatic tReset();
    logic ak;
    chk(!sdaDrvLow && !pbWrEn && !memRdEn && !pbCommit && !pbDrop, "R1 outputs idle after reset",
        {sdaDrvLow, pbWrEn, memRdEn, pbCommit, pbDrop}, 0);
    busStart();
    sendB(8'hA1, ak);
    chk(ak, "R1 current read ctrl ack", ak, 1);
    seqRead(8'h00, 1, "R1 R7 first current read at 0x00");
    busStop();
  endtask

  task automatic tByteWrite();
    logic ak, h, r;
    int   c0;
    c0 = commitCnt;
    busStart();
    sendByte(8'hA0, ak, h, r);
    chk(ak && h, "R4 ack held through ninth high", {ak, h}, 3);
    chk(r, "R4 released after ninth fall", r, 1);
    sendB(8'h20, ak);
    sendB(8'h5A, ak);
    chk(ak, "R5 data byte ack", ak, 1);
    chk(wrLog[wrCnt - 1] == 8'h20, "R5 write address", wrLog[wrCnt - 1], 8'h20);
    busStop();
    refMem[8'h20] = 8'h5A;
    chk(commitCnt == c0 + 1, "R6 commit after stop", commitCnt, c0 + 1);
    busStart();
    sendB(8'hA0, ak);
    chk(!ak, "R3 no ack while busy", ak, 0);
    busStop();
    waitIdle();
    c0 = commitCnt;
    busStart();
    sendB(8'hA0, ak);
    chk(ak, "R3 ack once idle", ak, 1);
    busStop();
    chk(commitCnt == c0, "R6 no commit without data", commitCnt, c0);
    randomRead(8'h20, 1, "R7 byte write readback");
  endtask

  task automatic tPageWrap();
    logic ak;
    int   w0;
    logic [7:0] expA [4];
    expA[0] = 8'h3E; expA[1] = 8'h3F; expA[2] = 8'h38; expA[3] = 8'h39;
    w0 = wrCnt;
    busStart();
    sendB(8'hA0, ak);
    sendB(8'h3E, ak);
    for (int k = 0; k < 4; k++) begin
      sendB(8'(8'h11 * (k + 1)), ak);
      chk(ak, "R5 page data ack", ak, 1);
    end
    busStop();
    for (int k = 0; k < 4; k++) begin
      chk(wrLog[w0 + k] == expA[k], "R5 page wrap address", wrLog[w0 + k], expA[k]);
      refMem[expA[k]] = 8'(8'h11 * (k + 1));
    end
    waitIdle();
    busStart();
    sendB(8'hA1, ak);
    seqRead(8'h3A, 1, "R7 current read after page write");
    busStop();
    randomRead(8'h38, 8, "R8 sequential over page");
    busStart();
    sendB(8'hA1, ak);
    seqRead(8'h40, 1, "R7 current read after sequential read");
    busStop();
  endtask

  task automatic tFullWrap();
    logic ak;
    logic moved;
    randomRead(8'hFE, 3, "R8 pointer wrap FF to 00");
    busStart();
    sendB(8'hA0, ak);
    sendB(8'hFF, ak);
    busStart();
    sendB(8'hA1, ak);
    seqRead(8'hFF, 1, "R9 single read before nack");
    moved = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk) mSda = 1'b0;
      clkRise();
      if (sdaDrvLow) moved = 1'b1;
      clkFall();
      if (sdaDrvLow) moved = 1'b1;
    end
    chk(!moved, "R9 released after master nack", moved, 0);
    busStop();
  endtask

  task automatic tCtrlMatch();
    logic ak;
    busStart();
    sendB(8'hAE, ak);
    chk(ak, "R2 middle bits ignored", ak, 1);
    busStop();
    busStart();
    sendB(8'hB0, ak);
    chk(!ak, "R2 wrong code no ack", ak, 0);
    sendB(8'hA0, ak);
    chk(!ak, "R2 ignored until next start", ak, 0);
    busStop();
    busStart();
    sendB(8'h51, ak);
    chk(!ak, "R2 wrong code read no ack", ak, 0);
    busStop();
  endtask

  task automatic tAbort();
    logic ak;
    int   w0, c0, d0;
    w0 = wrCnt; c0 = commitCnt;
    busStart();
    sendB(8'hA0, ak);
    sendB(8'h70, ak);
    for (int i = 0; i < 4; i++) mBit(1'b1);
    busStop();
    chk(wrCnt == w0 && commitCnt == c0, "R10 partial byte not written", wrCnt - w0, 0);
    chk(!sdaDrvLow, "R10 SDA released after stop", sdaDrvLow, 0);
    busStart();
    sendB(8'hA1, ak);
    seqRead(8'h70, 1, "R10 pointer kept after abort");
    busStop();
    d0 = dropCnt; c0 = commitCnt;
    busStart();
    sendB(8'hA0, ak);
    sendB(8'h71, ak);
    sendB(8'h99, ak);
    busStart();
    chk(dropCnt == d0 + 1 && commitCnt == c0, "R6 repeated start drops data", dropCnt - d0, 1);
    sendB(8'hA1, ak);
    chk(ak, "R10 new control byte after start", ak, 1);
    seqRead(8'h72, 1, "R6 pointer kept after repeated start");
    busStop();
    randomRead(8'h71, 1, "R6 dropped byte not stored");
  endtask

  task automatic tBusyEdge(input logic busyAt8, input string tag);
    logic ak, h, r;
    forceBusy = !busyAt8;
    busStart();
    for (int i = 7; i >= 1; i--) mBit(1'b1 ^ (i[0] ^ 1'b0) ? 1'b1 : 1'b0);
    busStop();
    forceBusy = !busyAt8;
    busStart();
    for (int i = 7; i >= 1; i--) mBit(8'hA0 >> i);
    @(negedge clk) begin mSda = 1'b0; sclRise = 1'b1; forceBusy = busyAt8; end
    @(negedge clk) sclRise = 1'b0;
    repeat (2) @(negedge clk);
    clkFall();
    @(negedge clk) mSda = 1'b1;
    clkRise();
    ak = sdaDrvLow;
    clkFall();
    h = 1'b0; r = 1'b0;
    chk(ak == !busyAt8, tag, ak, !busyAt8);
    busStop();
    forceBusy = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i * 7 + 3) ^ 8'h5C;
      refMem[i] = 8'(i * 7 + 3) ^ 8'h5C;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tByteWrite();
    tPageWrap();
    tFullWrap();
    tCtrlMatch();
    tAbort();
    tBusyEdge(1'b1, "R3 busy rising on eighth strobe gives nack");
    tBusyEdge(1'b0, "R3 busy falling on eighth strobe gives ack");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

endmodule